// File: doc/BRIEF.md
# Dual-Thread Core Power-State Controller

This block sits beside a core that two hardware threads share. It records the low-power level each thread asks for and decides the power state of the whole core. A thread can ask for a level in three ways. It can do a decoded I/O read of one of the two level registers in the power block, a level-2 register or a level-4 register. It can execute a wait instruction that names a target level. It can execute a halt.

The core sleeps only as deep as the shallower of the two requests, and only when both threads are asleep. The core uses its shallow states as follows:
- In C1 it keeps serving snoops.
- In C2 it drops into a one-cycle snoopable sub-state for each bus snoop.
- In C2 it acknowledges the chipset's stop-grant only while the active-low stop-clock input is low.

The deepest state, C4, runs in this order:
1. A cache-flush handshake runs to completion.
2. The core clock gate closes.
3. Snoop traffic is ignored from then on.
4. With both configuration enables set, the block asks for package deeper sleep.

An interrupt or break on either thread brings the core back to C0. From C4 the clocks restart one cycle before the thread requests clear.

Top module: `core_cstate_ctrl`

## Requirements
- R1: While reset is asserted, and after it, each thread level reads 0 (C0), `core_state_o` is 0, and `snoop_sub_o`, `flush_req_o`, `clk_gate_o`, `stop_grant_ack_o` and `pkg_dsleep_req_o` are low.
- R2: A request sets the level of its thread on the next clock edge, and is taken only while the core is in C0. The encoding is C0=0, C1=1, C2=2, C4=3, and thread t sits in `thr_state_o[2t+1:2t]`. The sources set the level as follows:
  - a halt gives 1;
  - a wait instruction gives its 2-bit target from `mwait_tgt_i[2t+1:2t]`;
  - an I/O read gives 3 when `io_rd_lvl4_i[t]` is set and 2 otherwise.
  Within one thread the priority is wake, then halt, then wait, then I/O read.
- R3: The core moves from C0 to the minimum of the two thread levels, on the same edge that the later request is recorded. While either thread is at level 0 the core stays in C0.
- R4: In C1 a snoop changes neither the core state nor `snoop_sub_o`.
- R5: `stop_grant_ack_o` is high only when the core is in C2 outside the snoop sub-state and `stpclk_ni` is low.
- R6: A snoop in C2 raises `snoop_sub_o` for exactly one cycle, with `core_state_o` still 2. The core then returns to C2.
- R7: When C4 is entered, `flush_req_o` stays high until `flush_done_i` is sampled high. `clk_gate_o` rises on the cycle after that sample, and `core_state_o` reads 3 throughout.
- R8: Snoops affect neither the flush nor the clock gate. A gated core stays gated until a wake.
- R9: `pkg_dsleep_req_o` is high only while the clocks are gated in C4 and both `cfg_dsleep_en_i` and `cfg_dcs_en_i` are high.
- R10: In C0, C1 or C2, a wake on a thread clears that thread's level, and the core goes to C0 on the same edge. In C4 a wake first ungates the clock while the state reads 3 and the levels stay put. One cycle later both levels clear and the core is in C0.
- R11: A wake during the flush is remembered. The flush completes, the core gates for one cycle, and the clock restart of R10 then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_rd_vld_i | input | 2 | Per thread: decoded read of a power-block level register |
| io_rd_lvl4_i | input | 2 | Per thread: the read hit the level-4 register (else level-2) |
| mwait_vld_i | input | 2 | Per thread: wait instruction issued |
| mwait_tgt_i | input | 4 | Per thread: 2-bit target level of the wait |
| halt_i | input | 2 | Per thread: halt executed |
| wake_i | input | 2 | Per thread: interrupt or break event |
| snoop_i | input | 1 | Bus snoop presented to the core |
| stpclk_ni | input | 1 | Chipset stop-clock request, active low |
| cfg_dsleep_en_i | input | 1 | Deeper-sleep enable bit |
| cfg_dcs_en_i | input | 1 | Dynamic cache sizing enable bit |
| flush_done_i | input | 1 | Cache flush complete pulse |
| core_state_o | output | 2 | Core state, encoded 0/1/2/3 = C0/C1/C2/C4 |
| snoop_sub_o | output | 1 | Core is in the C2 snoopable sub-state |
| flush_req_o | output | 1 | Request to flush the core caches to the shared cache |
| clk_gate_o | output | 1 | Core clocks stopped |
| stop_grant_ack_o | output | 1 | Stop-grant acknowledge |
| pkg_dsleep_req_o | output | 1 | Package deeper-sleep request |
| thr_state_o | output | 4 | Recorded level of each thread |

## Verification
The stimulus targets the following corner cases:
- **One thread asleep while the other runs.** A controller that acts on one request would leave C0 here.
- **A halt paired with a level-4 read.** Taking the deeper level would flush when only C1 is owed.
- **Snoops in each state.** In C1 a snoop must not start a sub-state. In C2 a sub-state that stuck would hide the stop-grant. In C4 a snoop that woke the core would ungate the clocks.
- **The C4 exit.** The gate must drop one cycle before the levels clear; a wrong order clears them while the clock is still stopped.
- **A wake during the flush.** A design that dropped it would stay gated for ever.
- **A single configuration enable.** It must not raise the package request.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_C0 = 2'd0;
  localparam lvl_t LVL_C1 = 2'd1;
  localparam lvl_t LVL_C2 = 2'd2;
  localparam lvl_t LVL_C4 = 2'd3;

  typedef enum logic [2:0] {
    CS_C0,
    CS_C1,
    CS_C2,
    CS_C2_SNP,
    CS_FLUSH,
    CS_C4,
    CS_RESTART
  } core_st_e;
endpackage

// File: rtl/cst_thread_req.sv
module cst_thread_req
  import cst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic freeze_i,
  input  logic clr_i,
  input  logic io_vld_i,
  input  logic io_lvl4_i,
  input  logic mw_vld_i,
  input  lvl_t mw_tgt_i,
  input  logic halt_i,
  input  logic wake_i,
  output lvl_t lvl_q_o,
  output lvl_t lvl_d_o
);
  lvl_t lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (clr_i)                lvl_d = LVL_C0;
    else if (!freeze_i) begin
      if (wake_i)             lvl_d = LVL_C0;
      else if (accept_i) begin
        if (halt_i)           lvl_d = LVL_C1;
        else if (mw_vld_i)    lvl_d = mw_tgt_i;
        else if (io_vld_i)    lvl_d = io_lvl4_i ? LVL_C4 : LVL_C2;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= LVL_C0;
    else         lvl_q <= lvl_d;

  assign lvl_q_o = lvl_q;
  assign lvl_d_o = lvl_d;
endmodule

// File: rtl/cst_core_fsm.sv
module cst_core_fsm
  import cst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_t     common_d_i,
  input  logic     snoop_i,
  input  logic     wake_any_i,
  input  logic     flush_done_i,
  output core_st_e state_o
);
  core_st_e st_q, st_d;
  logic     wake_pend_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CS_C0: begin
        unique case (common_d_i)
          LVL_C1:  st_d = CS_C1;
          LVL_C2:  st_d = CS_C2;
          LVL_C4:  st_d = CS_FLUSH;
          default: st_d = CS_C0;
        endcase
      end
      CS_C1:      if (common_d_i == LVL_C0) st_d = CS_C0;
      CS_C2: begin
        if (common_d_i == LVL_C0) st_d = CS_C0;
        else if (snoop_i)         st_d = CS_C2_SNP;
      end
      CS_C2_SNP:  st_d = (common_d_i == LVL_C0) ? CS_C0 : CS_C2;
      CS_FLUSH:   if (flush_done_i) st_d = CS_C4;
      CS_C4:      if (wake_any_i || wake_pend_q) st_d = CS_RESTART;
      CS_RESTART: st_d = CS_C0;
      default:    st_d = CS_C0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q        <= CS_C0;
      wake_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // a wake during the flush is held until the gated state is reached
      if (st_q == CS_FLUSH && wake_any_i) wake_pend_q <= 1'b1;
      else if (st_q == CS_RESTART)        wake_pend_q <= 1'b0;
    end

  assign state_o = st_q;
endmodule

// File: rtl/core_cstate_ctrl.sv
module core_cstate_ctrl
  import cst_pkg::*;
#(
  parameter int unsigned NUM_THR = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_THR-1:0]         io_rd_vld_i,
  input  logic [NUM_THR-1:0]         io_rd_lvl4_i,
  input  logic [NUM_THR-1:0]         mwait_vld_i,
  input  logic [LVL_W*NUM_THR-1:0]   mwait_tgt_i,
  input  logic [NUM_THR-1:0]         halt_i,
  input  logic [NUM_THR-1:0]         wake_i,
  input  logic                       snoop_i,
  input  logic                       stpclk_ni,
  input  logic                       cfg_dsleep_en_i,
  input  logic                       cfg_dcs_en_i,
  input  logic                       flush_done_i,
  output logic [LVL_W-1:0]           core_state_o,
  output logic                       snoop_sub_o,
  output logic                       flush_req_o,
  output logic                       clk_gate_o,
  output logic                       stop_grant_ack_o,
  output logic                       pkg_dsleep_req_o,
  output logic [LVL_W*NUM_THR-1:0]   thr_state_o
);
  core_st_e state;
  lvl_t     thr_d [NUM_THR];
  lvl_t     common_d;
  logic     accept, freeze, clr_all;

  assign accept  = (state == CS_C0);
  assign freeze  = (state == CS_FLUSH) || (state == CS_C4) || (state == CS_RESTART);
  assign clr_all = (state == CS_RESTART);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    lvl_t lvl_q;
    cst_thread_req u_thr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .accept_i  (accept),
      .freeze_i  (freeze),
      .clr_i     (clr_all),
      .io_vld_i  (io_rd_vld_i[t]),
      .io_lvl4_i (io_rd_lvl4_i[t]),
      .mw_vld_i  (mwait_vld_i[t]),
      .mw_tgt_i  (mwait_tgt_i[LVL_W*t +: LVL_W]),
      .halt_i    (halt_i[t]),
      .wake_i    (wake_i[t]),
      .lvl_q_o   (lvl_q),
      .lvl_d_o   (thr_d[t])
    );
    assign thr_state_o[LVL_W*t +: LVL_W] = lvl_q;
  end

  // shallowest next-cycle request across threads
  always_comb begin
    common_d = LVL_C4;
    for (int t = 0; t < NUM_THR; t++)
      if (thr_d[t] < common_d) common_d = thr_d[t];
  end

  cst_core_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .common_d_i   (common_d),
    .snoop_i      (snoop_i),
    .wake_any_i   (|wake_i),
    .flush_done_i (flush_done_i),
    .state_o      (state)
  );

  always_comb begin
    unique case (state)
      CS_C1:                          core_state_o = LVL_C1;
      CS_C2, CS_C2_SNP:               core_state_o = LVL_C2;
      CS_FLUSH, CS_C4, CS_RESTART:    core_state_o = LVL_C4;
      default:                        core_state_o = LVL_C0;
    endcase
  end

  assign snoop_sub_o      = (state == CS_C2_SNP);
  assign flush_req_o      = (state == CS_FLUSH);
  assign clk_gate_o       = (state == CS_C4);
  assign stop_grant_ack_o = (state == CS_C2) && !stpclk_ni;
  assign pkg_dsleep_req_o = (state == CS_C4) && cfg_dsleep_en_i && cfg_dcs_en_i;
endmodule

// File: rtl/cst_chk.sv
module cst_chk #(
  parameter int unsigned NUM_THR = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_THR-1:0]     io_rd_vld_i,
  input logic [NUM_THR-1:0]     io_rd_lvl4_i,
  input logic [NUM_THR-1:0]     mwait_vld_i,
  input logic [2*NUM_THR-1:0]   mwait_tgt_i,
  input logic [NUM_THR-1:0]     halt_i,
  input logic [NUM_THR-1:0]     wake_i,
  input logic                   snoop_i,
  input logic                   stpclk_ni,
  input logic                   cfg_dsleep_en_i,
  input logic                   cfg_dcs_en_i,
  input logic                   flush_done_i,
  input logic [1:0]             core_state_o,
  input logic                   snoop_sub_o,
  input logic                   flush_req_o,
  input logic                   clk_gate_o,
  input logic                   stop_grant_ack_o,
  input logic                   pkg_dsleep_req_o,
  input logic [2*NUM_THR-1:0]   thr_state_o
);
  logic all_asleep;
  always_comb begin
    all_asleep = 1'b1;
    for (int t = 0; t < NUM_THR; t++)
      if (thr_state_o[2*t +: 2] == 2'd0) all_asleep = 1'b0;
  end

  AST_BOTH_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_state_o != 2'd0 |-> all_asleep); // R3
  AST_SGA_STPCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_grant_ack_o |-> !stpclk_ni && core_state_o == 2'd2 && !snoop_sub_o); // R5
  AST_SNP_SUB_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_sub_o |=> !snoop_sub_o && core_state_o != 2'd1); // R6
  AST_FLUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o && !flush_done_i |=> flush_req_o); // R7
  AST_GATE_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_gate_o) |-> $past(flush_req_o) && $past(flush_done_i)); // R7
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_gate_o && $past(clk_gate_o) && wake_i == '0 |=> clk_gate_o); // R8
  AST_DSLEEP_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_dsleep_req_o |-> clk_gate_o && cfg_dsleep_en_i && cfg_dcs_en_i); // R9
  AST_UNGATE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_gate_o) |-> core_state_o == 2'd3 && all_asleep); // R10
endmodule

bind core_cstate_ctrl cst_chk #(.NUM_THR(NUM_THR)) i_cst_chk (.*);

// File: tb/test_core_cstate_ctrl.sv
module test_core_cstate_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_VEC      = 23;

  typedef struct packed {
    logic [1:0] io;  logic [1:0] l4;  logic [1:0] mw;  logic [3:0] tgt;
    logic [1:0] halt; logic [1:0] wake; logic snp; logic stpn; logic cfg; logic fd;
    logic [1:0] st; logic sub; logic freq; logic gate; logic sga; logic dsl; logic [3:0] thr;
    logic [3:0] req;
  } vec_t;

  // io,l4,mw,tgt,halt,wake,snp,stpn,cfg,fd | st,sub,freq,gate,sga,dsl,thr | req
  localparam vec_t VEC [N_VEC] = '{
    '{2'b00,2'b00,2'b00,4'b0000,2'b01,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001, 4'd3},  // R3 single
    '{2'b00,2'b00,2'b00,4'b0000,2'b10,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0101, 4'd3},  // R3 both C1
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0101, 4'd4},  // R4
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b10,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001, 4'd10}, // R10
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b01,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000, 4'd10}, // R10
    '{2'b01,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0010, 4'd2},  // R2 lvl2 read
    '{2'b00,2'b00,2'b10,4'b1000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1010, 4'd5},  // R5 no ack
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,4'b1010, 4'd5},  // R5 ack
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b1,1'b1,1'b0,1'b0, 2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1010, 4'd6},  // R6 sub
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1010, 4'd6},  // R6 back
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b01,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000, 4'd10}, // R10
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b10,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000, 4'd10}, // R10
    '{2'b01,2'b01,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0011, 4'd2},  // R2 lvl4 read
    '{2'b00,2'b00,2'b10,4'b1100,2'b00,2'b00,1'b0,1'b1,1'b1,1'b0, 2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,4'b1111, 4'd7},  // R7 flush
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b1,1'b1,1'b1,1'b0, 2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,4'b1111, 4'd8},  // R8
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b1,1'b1, 2'd3,1'b0,1'b0,1'b1,1'b0,1'b1,4'b1111, 4'd7},  // R7 gate, R9
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b1,1'b1,1'b1,1'b0, 2'd3,1'b0,1'b0,1'b1,1'b0,1'b1,4'b1111, 4'd8},  // R8
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b01,1'b0,1'b1,1'b1,1'b0, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1111, 4'd10}, // R10 ungate
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000, 4'd10}, // R10 clear
    '{2'b01,2'b01,2'b00,4'b0000,2'b00,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0011, 4'd2},  // R2
    '{2'b00,2'b00,2'b00,4'b0000,2'b10,2'b00,1'b0,1'b1,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0111, 4'd3},  // R3 min
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b10,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0011, 4'd10}, // R10
    '{2'b00,2'b00,2'b00,4'b0000,2'b00,2'b01,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000, 4'd10}  // R10
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] io_rd_vld_i, io_rd_lvl4_i, mwait_vld_i, halt_i, wake_i;
  logic [3:0] mwait_tgt_i;
  logic       snoop_i, stpclk_ni, cfg_dsleep_en_i, cfg_dcs_en_i, flush_done_i;
  logic [1:0] core_state_o;
  logic       snoop_sub_o, flush_req_o, clk_gate_o, stop_grant_ack_o, pkg_dsleep_req_o;
  logic [3:0] thr_state_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  core_cstate_ctrl i_core_cstate_ctrl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [11:0] outs();
    return {core_state_o, snoop_sub_o, flush_req_o, clk_gate_o, stop_grant_ack_o,
            pkg_dsleep_req_o, thr_state_o};
  endfunction

  task automatic check(input string req, input logic [11:0] exp);
    logic [11:0] act = outs();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {st,sub,freq,gate,sga,dsl,thr} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    io_rd_vld_i = '0; io_rd_lvl4_i = '0; mwait_vld_i = '0; mwait_tgt_i = '0;
    halt_i = '0; wake_i = '0; snoop_i = 1'b0; stpclk_ni = 1'b1;
    cfg_dsleep_en_i = 1'b0; cfg_dcs_en_i = 1'b0; flush_done_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    idle();
    repeat (2) step();
    check("R1 reset", 12'b0);
    rst_ni = 1'b1;
    step();
    check("R1 after release", 12'b0);

    for (int i = 0; i < N_VEC; i++) begin
      io_rd_vld_i = VEC[i].io;  io_rd_lvl4_i = VEC[i].l4; mwait_vld_i = VEC[i].mw;
      mwait_tgt_i = VEC[i].tgt; halt_i = VEC[i].halt;    wake_i = VEC[i].wake;
      snoop_i = VEC[i].snp;     stpclk_ni = VEC[i].stpn;
      cfg_dsleep_en_i = VEC[i].cfg; cfg_dcs_en_i = VEC[i].cfg; flush_done_i = VEC[i].fd;
      step();
      check($sformatf("R%0d vec%0d", VEC[i].req, i),
            {VEC[i].st, VEC[i].sub, VEC[i].freq, VEC[i].gate, VEC[i].sga, VEC[i].dsl, VEC[i].thr});
    end

    // R11: wake during flush, with only one config enable (R9)
    idle(); io_rd_vld_i = 2'b01; io_rd_lvl4_i = 2'b01; step();
    idle(); mwait_vld_i = 2'b10; mwait_tgt_i = 4'b1100; step();
    check("R7 flush entry", {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1111});
    idle(); wake_i = 2'b01; cfg_dsleep_en_i = 1'b1; step();
    check("R11 wake held in flush", {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1111});
    idle(); flush_done_i = 1'b1; cfg_dsleep_en_i = 1'b1; step();
    check("R9 one enable only", {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1111});
    idle(); cfg_dsleep_en_i = 1'b1; step();
    check("R11 restart", {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111});
    idle(); step();
    check("R11 cleared", 12'b0);

    // R2: halt beats wait in same thread; R1: reset mid-run
    idle(); halt_i = 2'b11; mwait_vld_i = 2'b11; mwait_tgt_i = 4'b1111; step();
    check("R2 halt priority", {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101});
    idle(); #1 rst_ni = 1'b0; step();
    check("R1 mid reset", 12'b0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule